// File: doc/BRIEF.md
# Write-Through Direct-Mapped Data Cache

This block sits between a processor's load/store port and a slower, word-wide backing memory. It holds 16 lines of four words each, one line per set. The word address splits into a tag, a set index and a word offset. A load that finds its line present returns the word in the same cycle. A load that misses holds the processor stalled while the whole line is fetched. Every store is copied to the backing memory in the cycle it is written into the cache. A store that misses first fetches its line, then writes the word.

The processor raises a request with an address, a write flag and the store data. It keeps these unchanged for as long as the stall output is high, and the access completes in the first cycle in which stall is low. The backing memory accepts a write in the cycle the write is presented. It answers a read request with a ready pulse that carries the data, one cycle after the request.

Top module: `wt_dcache`

## Requirements
- R1: After reset no line is valid. With no request the stall output is low, and the first load to any address misses.
- R2: Address bits [7:6] are the tag, bits [5:2] the set index and bits [1:0] the word offset. Two addresses that share an index but differ in tag evict each other, so each access after the other's fill misses again.
- R3: A load whose line is present completes in its first cycle, with stall low and the addressed word on the read data output.
- R4: A load miss holds stall high for exactly 8 cycles. In the cycle after them the load completes and returns the word that memory holds.
- R5: A line fill issues four memory read requests, for offsets 0, 1, 2 and 3 in that order. Each carries the missing tag and index, and they are spaced 2 cycles apart, starting in the cycle of the miss.
- R6: A store whose line is present completes without a stall. In the same cycle it writes the cache word and presents one memory write with the same address and data.
- R7: A store miss holds stall high for exactly 9 cycles: the line fill, then one cycle that writes the word into the cache and issues exactly one memory write. Afterwards the word reads back as a hit with the stored value, and the other words of the line hold memory's values.
- R8: The backing memory always holds the latest stored value. A line that is evicted and fetched again returns the stored data.
- R9: No memory write is issued for a load, whether it hits or misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 8 | Word address {tag, index, offset} |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when an access completes |
| cpu_stall | output | 1 | High while the access cannot complete |
| mem_req | output | 1 | Backing memory request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 8 | Backing memory word address |
| mem_wdata | output | 32 | Backing memory write data |
| mem_rdata | input | 32 | Backing memory read data, valid with ready |
| mem_ready | input | 1 | Read data valid, one cycle after a read request |

## Verification
Stall and read data are combinational in the cycle of a request. A hit therefore completes in the cycle it is driven, a load miss 8 cycles later and a store miss 9 cycles later. The memory write of a store hit lands on the clock edge that ends its cycle, and that of a store miss on the edge that ends its ninth stall cycle. Inputs change only on falling edges. Each access task samples stall one time unit after a falling edge and counts one cycle per falling edge while stall stays high. It reads the data only in the first low-stall cycle, and it checks memory writes and the logged fill requests only after the next falling edge, when every due edge has passed.

// File: rtl/wt_dcache_pkg.sv
// Shared types for the write-through data cache.
package wt_dcache_pkg;
    // Controller states: waiting for accesses, fetching a line, finishing a store miss
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_STORE = 2'd2
    } dc_state_e;
endpackage

// File: rtl/dc_tag_store.sv
// Valid and tag array, one entry per set.
// Lookup is combinational. A write marks the set valid with a new tag.
// Assumes a write happens only at the end of a line fill.
module dc_tag_store #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0]  vld_q;
    logic [TAG_W-1:0] tag_q [SETS];

    // Clear valid bits on reset, set one on a fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    // Record the tag of the filled line
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    // Compare the stored tag for the looked-up set
    always_comb begin
        lk_hit = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    end

    // R2: a filled set holds the written tag on the next cycle
    a_r2_tag_written: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (vld_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)));
endmodule

// File: rtl/dc_data_store.sv
// Data array of SETS lines by WORDS words with one combinational read port
// and one synchronous write port. The contents are not reset, because
// validity is tracked in the tag store.
module dc_data_store #(
    parameter int IDX_W  = 4,
    parameter int OFF_W  = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int ENTRIES = 1 << (IDX_W + OFF_W);

    logic [DATA_W-1:0] mem_q [ENTRIES];

    // Write one word
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[{wr_idx, wr_off}] <= wr_data;
        end
    end

    // Read the addressed word
    always_comb begin
        rd_data = mem_q[{rd_idx, rd_off}];
    end
endmodule

// File: rtl/dc_fill_ctrl.sv
// Miss sequencer. On a miss it walks the line's words in offset order.
// Each word takes a request cycle and then a cycle that waits for ready.
// A store miss ends with one extra cycle that performs the store, then
// raises a one-cycle retire flag so the held request is not repeated.
// Assumes memory answers reads with ready; writes need no answer.
module dc_fill_ctrl
    import wt_dcache_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_we,
    input  logic             mem_ready,
    output dc_state_e        state,
    output logic [OFF_W-1:0] word_sel,
    output logic             fill_req,
    output logic             fill_wr,
    output logic             fill_done,
    output logic             store_now,
    output logic             retire
);
    localparam int CW = OFF_W + 1;
    localparam logic [CW-1:0] LAST = {CW{1'b1}};
    localparam logic [CW-1:0] ONE  = CW'(1);

    dc_state_e     state_q;
    logic [CW-1:0] cnt_q;
    logic          we_q;
    logic          retire_q;

    // Step the sequencer through the fill and the store cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            we_q     <= 1'b0;
            retire_q <= 1'b0;
        end else begin
            retire_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_FILL;
                        cnt_q   <= ONE;
                        we_q    <= start_we;
                    end
                end
                ST_FILL: begin
                    if (!cnt_q[0]) begin
                        cnt_q <= cnt_q + ONE;
                    end else if (mem_ready) begin
                        if (cnt_q == LAST) begin
                            cnt_q   <= '0;
                            state_q <= we_q ? ST_STORE : ST_IDLE;
                        end else begin
                            cnt_q <= cnt_q + ONE;
                        end
                    end
                end
                ST_STORE: begin
                    state_q  <= ST_IDLE;
                    retire_q <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Decode the per-cycle actions of the sequencer
    always_comb begin
        state     = state_q;
        word_sel  = cnt_q[OFF_W:1];
        fill_req  = (state_q == ST_IDLE && start) || (state_q == ST_FILL && !cnt_q[0]);
        fill_wr   = (state_q == ST_FILL) && cnt_q[0] && mem_ready;
        fill_done = fill_wr && (cnt_q == LAST);
        store_now = (state_q == ST_STORE);
        retire    = retire_q;
    end

    // R4: a load fill returns to idle right after its last word
    a_r4_load_fill_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && cnt_q == LAST && mem_ready && !we_q) |=> (state_q == ST_IDLE));
    // R7: a store fill is followed by the store cycle
    a_r7_store_follows_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && cnt_q == LAST && mem_ready && we_q) |=> (state_q == ST_STORE));
endmodule

// File: rtl/wt_dcache.sv
// Write-through direct-mapped data cache, top level.
// Loads hit in the request cycle. Misses fetch the whole line in offset
// order, and every store is written to memory in the cycle it updates the
// cache. Assumes the processor holds its request while stall is high.
module wt_dcache
    import wt_dcache_pkg::*;
#(
    parameter int TAG_W  = 2,
    parameter int IDX_W  = 4,
    parameter int OFF_W  = 2,
    parameter int DATA_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cpu_req,
    input  logic                           cpu_we,
    input  logic [TAG_W+IDX_W+OFF_W-1:0]   cpu_addr,
    input  logic [DATA_W-1:0]              cpu_wdata,
    output logic [DATA_W-1:0]              cpu_rdata,
    output logic                           cpu_stall,
    output logic                           mem_req,
    output logic                           mem_we,
    output logic [TAG_W+IDX_W+OFF_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]              mem_wdata,
    input  logic [DATA_W-1:0]              mem_rdata,
    input  logic                           mem_ready
);
    localparam int ADDR_W = TAG_W + IDX_W + OFF_W;

    logic [TAG_W-1:0]  a_tag;
    logic [IDX_W-1:0]  a_idx;
    logic [OFF_W-1:0]  a_off;
    logic [TAG_W-1:0]  m_tag_q;
    logic [IDX_W-1:0]  m_idx_q;
    logic [OFF_W-1:0]  m_off_q;
    logic [DATA_W-1:0] m_wdata_q;
    logic [TAG_W-1:0]  cur_tag;
    logic [IDX_W-1:0]  cur_idx;
    logic              hit, idle, start, wr_hit;
    dc_state_e         state;
    logic [OFF_W-1:0]  word_sel;
    logic              fill_req, fill_wr, fill_done, store_now, retire;
    logic              d_we;
    logic [IDX_W-1:0]  d_idx;
    logic [OFF_W-1:0]  d_off;
    logic [DATA_W-1:0] d_wdata;

    // Split the processor address and classify the request
    always_comb begin
        a_tag   = cpu_addr[ADDR_W-1 -: TAG_W];
        a_idx   = cpu_addr[OFF_W +: IDX_W];
        a_off   = cpu_addr[OFF_W-1:0];
        idle    = (state == ST_IDLE);
        start   = idle && cpu_req && !hit && !retire;
        wr_hit  = idle && cpu_req && cpu_we && hit && !retire;
        cpu_stall = !idle || start;
        cur_tag = idle ? a_tag : m_tag_q;
        cur_idx = idle ? a_idx : m_idx_q;
    end

    // Capture the missing access so the fill does not depend on held inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_tag_q   <= '0;
            m_idx_q   <= '0;
            m_off_q   <= '0;
            m_wdata_q <= '0;
        end else if (start) begin
            m_tag_q   <= a_tag;
            m_idx_q   <= a_idx;
            m_off_q   <= a_off;
            m_wdata_q <= cpu_wdata;
        end
    end

    // Pick the data array write source: fill word, store-miss word or store hit
    always_comb begin
        d_we    = fill_wr || store_now || wr_hit;
        d_idx   = a_idx;
        d_off   = a_off;
        d_wdata = cpu_wdata;
        if (fill_wr) begin
            d_idx   = m_idx_q;
            d_off   = word_sel;
            d_wdata = mem_rdata;
        end else if (store_now) begin
            d_idx   = m_idx_q;
            d_off   = m_off_q;
            d_wdata = m_wdata_q;
        end
    end

    // Drive the backing memory: fill reads or write-through stores
    always_comb begin
        mem_req   = fill_req || store_now || wr_hit;
        mem_we    = store_now || wr_hit;
        mem_wdata = store_now ? m_wdata_q : cpu_wdata;
        if (fill_req) begin
            mem_addr = {cur_tag, cur_idx, word_sel};
        end else if (store_now) begin
            mem_addr = {m_tag_q, m_idx_q, m_off_q};
        end else begin
            mem_addr = cpu_addr;
        end
    end

    dc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) tags_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .lk_idx (a_idx),
        .lk_tag (a_tag),
        .lk_hit (hit),
        .wr_en  (fill_done),
        .wr_idx (m_idx_q),
        .wr_tag (m_tag_q)
    );

    dc_data_store #(.IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) data_i (
        .clk     (clk),
        .rd_idx  (a_idx),
        .rd_off  (a_off),
        .rd_data (cpu_rdata),
        .wr_en   (d_we),
        .wr_idx  (d_idx),
        .wr_off  (d_off),
        .wr_data (d_wdata)
    );

    dc_fill_ctrl #(.OFF_W(OFF_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_we  (cpu_we),
        .mem_ready (mem_ready),
        .state     (state),
        .word_sel  (word_sel),
        .fill_req  (fill_req),
        .fill_wr   (fill_wr),
        .fill_done (fill_done),
        .store_now (store_now),
        .retire    (retire)
    );

    // R5: a fill read request lasts one cycle, then waits for the answer
    a_r5_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> !(mem_req && !mem_we));
    // R9: an idle-cycle memory write only comes from a processor store
    a_r9_write_needs_store: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && idle) |-> (cpu_req && cpu_we));
    // R6: a store hit goes through to memory unchanged, without a stall
    a_r6_hit_write_through: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |-> (mem_req && mem_we && mem_addr == cpu_addr && mem_wdata == cpu_wdata && !cpu_stall));
    // R1: no stall while idle without a request
    a_r1_idle_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !cpu_req) |-> !cpu_stall);
endmodule

// File: tb/wt_dcache_tb_top.sv
// Directed bench: one task per scenario, with a word-wide memory model
// that answers reads one cycle after the request.
module wt_dcache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_stall;
    logic        mem_req, mem_we;
    logic [7:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ready;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    wt_dcache dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready)
    );

    // Initial memory contents, computed from the address
    function automatic logic [31:0] init_val(input logic [7:0] a);
        return {16'hD00D, ~a, a};
    endfunction

    // Backing memory model
    logic        mflag [256];
    logic [31:0] mdata [256];
    int          wr_count = 0;
    logic [7:0]  last_wa;
    logic [31:0] last_wd;
    logic [7:0]  log_addr [64];
    int          log_cyc  [64];
    int          log_n = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            mem_ready <= 1'b0;
            mem_rdata <= '0;
            for (int i = 0; i < 256; i++) mflag[i] <= 1'b0;
        end else begin
            mem_ready <= mem_req && !mem_we;
            mem_rdata <= mflag[mem_addr] ? mdata[mem_addr] : init_val(mem_addr);
            if (mem_req && mem_we) begin
                mflag[mem_addr] <= 1'b1;
                mdata[mem_addr] <= mem_wdata;
                wr_count <= wr_count + 1;
                last_wa  <= mem_addr;
                last_wd  <= mem_wdata;
            end
            if (mem_req && !mem_we && log_n < 64) begin
                log_addr[log_n] <= mem_addr;
                log_cyc[log_n]  <= cyc;
                log_n <= log_n + 1;
            end
        end
    end

    // Bench-side expected memory contents
    logic        eflag [256];
    logic [31:0] edata [256];

    function automatic logic [31:0] exp_val(input logic [7:0] a);
        return eflag[a] ? edata[a] : init_val(a);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access from a falling edge: count stall cycles, return data, idle one cycle
    task automatic access(input bit we, input logic [7:0] a, input logic [31:0] wd,
                          output int stalls, output logic [31:0] rd);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        stalls = 0;
        #1;
        while (cpu_stall && stalls < 50) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        rd = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        @(negedge clk);
        if (we) begin
            eflag[a] = 1'b1;
            edata[a] = wd;
        end
    endtask

    task automatic t_reset_and_first_load();
        int s; logic [31:0] d;
        #1;
        chk(!cpu_stall, "R1 no stall when idle", 32'(cpu_stall), 0);
        access(1'b0, 8'h05, '0, s, d);
        chk(s == 8, "R1/R4 first load miss stall count", 32'(s), 8);
        chk(d == exp_val(8'h05), "R4 miss load data", d, exp_val(8'h05));
    endtask

    task automatic t_load_hits();
        int s; logic [31:0] d;
        access(1'b0, 8'h07, '0, s, d);
        chk(s == 0, "R3 hit no stall", 32'(s), 0);
        chk(d == exp_val(8'h07), "R3 hit data offset 3", d, exp_val(8'h07));
        access(1'b0, 8'h04, '0, s, d);
        chk(d == exp_val(8'h04) && s == 0, "R3 hit data offset 0", d, exp_val(8'h04));
    endtask

    task automatic t_fill_order();
        int s; int base; logic [31:0] d;
        base = log_n;
        access(1'b0, 8'h32, '0, s, d);
        chk(log_n - base == 4, "R5 fill request count", 32'(log_n - base), 4);
        for (int k = 0; k < 4; k++) begin
            chk(log_addr[base+k] == (8'h30 | 8'(k)), "R5 fill request address order",
                32'(log_addr[base+k]), 32'(8'h30 | 8'(k)));
            if (k > 0)
                chk(log_cyc[base+k] - log_cyc[base+k-1] == 2, "R5 fill request spacing",
                    32'(log_cyc[base+k] - log_cyc[base+k-1]), 2);
        end
        chk(d == exp_val(8'h32), "R4 fill data", d, exp_val(8'h32));
    endtask

    task automatic t_store_hit();
        int s; int w0; logic [31:0] d;
        w0 = wr_count;
        access(1'b1, 8'h06, 32'hCAFE_0006, s, d);
        chk(s == 0, "R6 store hit no stall", 32'(s), 0);
        chk(wr_count - w0 == 1, "R6 one memory write", 32'(wr_count - w0), 1);
        chk(last_wa == 8'h06 && last_wd == 32'hCAFE_0006, "R6 write address/data", last_wd, 32'hCAFE_0006);
        access(1'b0, 8'h06, '0, s, d);
        chk(s == 0 && d == 32'hCAFE_0006, "R6 cache word updated", d, 32'hCAFE_0006);
    endtask

    task automatic t_store_miss();
        int s; int w0; logic [31:0] d;
        w0 = wr_count;
        access(1'b1, 8'h8A, 32'hBEEF_008A, s, d);
        chk(s == 9, "R7 store miss stall count", 32'(s), 9);
        chk(wr_count - w0 == 1, "R7 exactly one memory write", 32'(wr_count - w0), 1);
        chk(last_wa == 8'h8A && last_wd == 32'hBEEF_008A, "R7 write address/data", last_wd, 32'hBEEF_008A);
        access(1'b0, 8'h8A, '0, s, d);
        chk(s == 0 && d == 32'hBEEF_008A, "R7 stored word hits", d, 32'hBEEF_008A);
        access(1'b0, 8'h8B, '0, s, d);
        chk(s == 0 && d == exp_val(8'h8B), "R7 rest of line filled", d, exp_val(8'h8B));
    endtask

    task automatic t_conflict_and_no_load_writes();
        int s; int w0; logic [31:0] d;
        w0 = wr_count;
        access(1'b0, 8'h45, '0, s, d);
        chk(s == 8, "R2 same index other tag misses", 32'(s), 8);
        chk(d == exp_val(8'h45), "R2 conflicting line data", d, exp_val(8'h45));
        access(1'b0, 8'h05, '0, s, d);
        chk(s == 8, "R2 evicted line misses again", 32'(s), 8);
        access(1'b0, 8'h06, '0, s, d);
        chk(s == 0 && d == 32'hCAFE_0006, "R8 stored value survives eviction", d, 32'hCAFE_0006);
        chk(wr_count == w0, "R9 loads make no memory writes", 32'(wr_count - w0), 0);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) eflag[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_and_first_load();
        t_load_hits();
        t_fill_order();
        t_store_hit();
        t_store_miss();
        t_conflict_and_no_load_writes();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule